// File: doc/BRIEF.md
# Page Write Buffer and Program Engine

This block sits behind a serial memory front-end and handles the data phase of a write instruction. Once the front-end has decoded a write command and its address, it pulses a start strobe with the address. Each data byte it assembles afterwards is presented with a one-cycle valid strobe. The engine stores each byte in a page buffer. The buffer's offset pointer advances on the five low address bits only, so it wraps within a 32-byte page. A per-byte valid mask records which offsets actually received data.

When chip select rises, the front-end reports the event together with a flag that tells whether a byte was only partly shifted in. If the rise lands on a byte boundary and at least one full byte was stored, the engine starts a program cycle. A program cycle lasts a fixed, parameterised number of clocks. During its first clocks the engine scans the buffer from offset 0 upward, one offset per clock, and writes every marked byte to the array. Busy stays high for the whole program cycle and the front-end reports it as status bit 0. On the clock after busy falls, the engine pulses a request to clear the write-enable latch. A chip-select rise in the middle of a byte, or after no data at all, returns the engine to idle without writing anything.

The controller has four states:
- IDLE: waits for a start strobe.
- COLLECT: stores bytes.
- PROGRAM: busy. The array scan and the cycle timer run in this state.
- FINISH: issues the latch-clear pulse.

It has six transitions:
- start: IDLE to COLLECT, on the start strobe.
- commit: COLLECT to PROGRAM, on a clean rise with data stored.
- abort: COLLECT to IDLE, on a rise in the middle of a byte or with no data stored.
- expire: PROGRAM to FINISH, when the timer runs out.
- release: FINISH to IDLE, always after one cycle.
- hold: every state keeps its value when none of the above applies.

Top module: `pw_engine`

## Requirements
- R1: Byte n of a transfer (counting from 0) is stored at offset (start_addr[4:0] + n) mod 32. Its array address is {start_addr[15:5], offset}, so the upper 11 address bits never change within one transfer.
- R2: When more than 32 bytes arrive, a later byte replaces the earlier byte at the same offset. Each offset is written to the array at most once per program cycle, with the last byte received for it.
- R3: The array write is asserted only for offsets that received a byte. These writes occur one per clock, in ascending offset order, during the first 32 clocks of the program cycle.
- R4: A chip-select rise (cs_rise high) with bit_partial low, after at least one full byte, starts a program cycle. Busy is high in the clock after the rise is sampled.
- R5: A chip-select rise with bit_partial high aborts the transfer. No array write, no busy and no latch-clear pulse follow.
- R6: A chip-select rise that follows the start strobe with no data byte programs nothing and leaves busy low.
- R7: Busy stays high for exactly PROG_CYCLES consecutive clocks per program cycle.
- R8: wel_clr is a one-clock pulse in the clock right after busy falls. It occurs once per completed program cycle and never at any other time.
- R9: While busy, the engine ignores wr_start, byte_vld and cs_rise. The array writes and the busy length of the running cycle stay unchanged.
- R10: After reset, busy, wel_clr and arr_we are low.
- R11: In idle, byte_vld and cs_rise have no effect. No busy, write or clear pulse follows them, and those bytes are not written by the next transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_start | input | 1 | Pulse: write command and address accepted |
| start_addr | input | 16 | First byte address of the transfer |
| byte_vld | input | 1 | Pulse: one full data byte available |
| byte_data | input | 8 | Data byte |
| cs_rise | input | 1 | Pulse: chip select went high |
| bit_partial | input | 1 | Qualifies cs_rise: a byte was only partly received |
| busy | output | 1 | Program cycle in progress |
| wel_clr | output | 1 | Pulse: clear the write-enable latch |
| arr_we | output | 1 | Array byte write strobe |
| arr_addr | output | 16 | Array byte address |
| arr_wdata | output | 8 | Array write data |

## Verification
A single byte in the middle of a page shows that the address is formed correctly and that a one-byte commit works. A short burst that starts at offset 30 separates true in-page wrap from a carry into the next page. A 40-byte burst shows replacement against duplicate writes. A sparse burst, with start, data and rise strobes injected while busy, checks that the mask limits writes and that the busy window cannot be restarted. A rise in the middle of a byte, a rise with no data, and strobes sent in idle each tell the three no-commit paths apart from a real commit.

// File: rtl/pw_pkg.sv
package pw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_PROGRAM = 2'd2,
        ST_FINISH  = 2'd3
    } pw_state_t;

endpackage

// File: rtl/pw_offset_ctr.sv
// Wrapping offset counter: load has priority over increment.
module pw_offset_ctr #(
    parameter int OFF_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [OFF_W-1:0] load_val,
    input  logic             inc,
    output logic [OFF_W-1:0] off
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off <= '0;
        end else if (load) begin
            off <= load_val;
        end else if (inc) begin
            off <= off + OFF_W'(1);
        end
    end

endmodule

// File: rtl/pw_page_buf.sv
// Page data store with per-byte valid mask.
module pw_page_buf #(
    parameter int PAGE_BYTES = 32,
    parameter int DATA_W     = 8,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_vld,
    output logic              any_vld
);

    logic [DATA_W-1:0]     slot_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mask_q;
    logic [PAGE_BYTES-1:0] hit;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_dec
        assign hit[g] = wr_en && (wr_off == OFF_W'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            for (int i = 0; i < PAGE_BYTES; i++) begin
                slot_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (clear) begin
                    mask_q[i] <= 1'b0;
                end else if (hit[i]) begin
                    mask_q[i] <= 1'b1;
                    slot_q[i] <= wr_data;
                end
            end
        end
    end

    assign rd_data = slot_q[rd_off];
    assign rd_vld  = mask_q[rd_off];
    assign any_vld = |mask_q;

endmodule

// File: rtl/pw_prog_timer.sv
// Down-counter for the program cycle; last is high on the final busy clock.
module pw_prog_timer #(
    parameter int PROG_CYCLES = 200,
    localparam int CNT_W      = $clog2(PROG_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick,
    output logic last
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_W'(PROG_CYCLES);
        end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/pw_engine.sv
module pw_engine #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int PAGE_BYTES  = 32,
    parameter int PROG_CYCLES = 200,
    localparam int OFF_W      = $clog2(PAGE_BYTES),
    localparam int BASE_W     = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              cs_rise,
    input  logic              bit_partial,
    output logic              busy,
    output logic              wel_clr,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata
);
    import pw_pkg::*;

    if (PROG_CYCLES < PAGE_BYTES) begin : g_bad_cfg
        $error("PROG_CYCLES must cover one scan of the page");
    end

    pw_state_t         state_q, state_d;
    logic [BASE_W-1:0] base_q;
    logic              scan_act_q;
    logic [OFF_W-1:0]  wr_off, scan_off;
    logic [DATA_W-1:0] rd_data;
    logic              rd_vld, any_vld, t_last;
    logic              take_start, take_byte, commit, scan_end;

    assign take_start = (state_q == ST_IDLE) && wr_start;
    assign take_byte  = (state_q == ST_COLLECT) && byte_vld;
    assign commit     = (state_q == ST_COLLECT) && cs_rise && !bit_partial
                        && (any_vld || byte_vld);
    assign scan_end   = (scan_off == OFF_W'(PAGE_BYTES - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: start, commit, abort, expire, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_start) state_d = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (cs_rise) state_d = commit ? ST_PROGRAM : ST_IDLE;
            end
            ST_PROGRAM: begin
                if (t_last) state_d = ST_FINISH;
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Page base and scan-active flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q     <= '0;
            scan_act_q <= 1'b0;
        end else begin
            if (take_start) begin
                base_q <= start_addr[ADDR_W-1:OFF_W];
            end
            if (commit) begin
                scan_act_q <= 1'b1;
            end else if (state_q == ST_PROGRAM && scan_end) begin
                scan_act_q <= 1'b0;
            end
        end
    end

    pw_offset_ctr #(.OFF_W(OFF_W)) u_wr_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take_start),
        .load_val (start_addr[OFF_W-1:0]),
        .inc      (take_byte),
        .off      (wr_off)
    );

    pw_offset_ctr #(.OFF_W(OFF_W)) u_scan_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (commit),
        .load_val ('0),
        .inc      (state_q == ST_PROGRAM && scan_act_q),
        .off      (scan_off)
    );

    pw_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (take_start),
        .wr_en   (take_byte),
        .wr_off  (wr_off),
        .wr_data (byte_data),
        .rd_off  (scan_off),
        .rd_data (rd_data),
        .rd_vld  (rd_vld),
        .any_vld (any_vld)
    );

    pw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (commit),
        .tick  (state_q == ST_PROGRAM),
        .last  (t_last)
    );

    // Outputs
    always_comb begin
        busy      = 1'b0;
        wel_clr   = 1'b0;
        arr_we    = 1'b0;
        arr_addr  = {base_q, scan_off};
        arr_wdata = rd_data;
        unique case (state_q)
            ST_IDLE, ST_COLLECT: ;
            ST_PROGRAM: begin
                busy   = 1'b1;
                arr_we = scan_act_q && rd_vld;
            end
            ST_FINISH: wel_clr = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/pw_engine_chk.sv
module pw_engine_chk #(
    parameter int ADDR_W      = 16,
    parameter int PROG_CYCLES = 200,
    parameter int OFF_W       = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_rise,
    input logic              bit_partial,
    input logic              busy,
    input logic              wel_clr,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr
);

    logic [31:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= busy ? run_q + 32'd1 : 32'd0;
    end

    AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy); // R3

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we)) |->
        arr_addr[ADDR_W-1:OFF_W] == $past(arr_addr[ADDR_W-1:OFF_W])); // R1

    AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_rise && !bit_partial)); // R4

    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && bit_partial && !busy) |=> !busy); // R5

    AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && run_q != 32'd0) |-> run_q == 32'(PROG_CYCLES)); // R7

    AST_CLR_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr |-> ($past(busy) && !busy)); // R8

    AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr |=> !wel_clr); // R8

endmodule

bind pw_engine pw_engine_chk #(
    .ADDR_W      (ADDR_W),
    .PROG_CYCLES (PROG_CYCLES),
    .OFF_W       (OFF_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_rise     (cs_rise),
    .bit_partial (bit_partial),
    .busy        (busy),
    .wel_clr     (wel_clr),
    .arr_we      (arr_we),
    .arr_addr    (arr_addr)
);

// File: tb/pw_engine_test.sv
`timescale 1ns/1ps
module pw_engine_test;
    localparam int P = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_start = 1'b0, byte_vld = 1'b0, cs_rise = 1'b0, bit_partial = 1'b0;
    logic [15:0] start_addr = '0;
    logic [7:0]  byte_data = '0;
    logic        busy, wel_clr, arr_we;
    logic [15:0] arr_addr;
    logic [7:0]  arr_wdata;

    int checks = 0, errors = 0;
    int rises = 0, clrs = 0, run = 0, last_len = 0;
    bit prev_busy = 1'b0, done = 1'b0;
    logic [15:0] q_addr[$];
    logic [7:0]  q_data[$];

    always #2 clk = ~clk;

    pw_engine #(.PROG_CYCLES(P)) uut (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .start_addr(start_addr),
        .byte_vld(byte_vld), .byte_data(byte_data), .cs_rise(cs_rise),
        .bit_partial(bit_partial), .busy(busy), .wel_clr(wel_clr),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Monitor: compares array writes against the scoreboard and tracks busy
    always @(negedge clk) begin
        if (rst_n) begin
            if (arr_we) begin
                if (q_addr.size() == 0) begin
                    check(1'b0, "R3", "unexpected array write addr", arr_addr, 0);
                end else begin
                    logic [15:0] ea;
                    logic [7:0]  ed;
                    ea = q_addr.pop_front();
                    ed = q_data.pop_front();
                    check(arr_addr == ea, "R1", "write address", arr_addr, ea);
                    check(arr_wdata == ed, "R2", "write data", arr_wdata, ed);
                end
            end
            if (busy && !prev_busy) rises++;
            if (busy) run++;
            if (!busy && prev_busy) begin
                last_len = run;
                run = 0;
                check(wel_clr == 1'b1, "R8", "clear pulse after busy falls", wel_clr, 1);
            end
            if (wel_clr) begin
                clrs++;
                if (!prev_busy) check(1'b0, "R8", "clear pulse without busy", 1, 0);
            end
            prev_busy = busy;
        end
    end

    // Driver: runs one transfer and fills the scoreboard
    task automatic do_write(input logic [15:0] addr, input int n, input int seed,
                            input bit partial, input bit noise, input string req);
        logic [7:0] md[32];
        bit         mm[32];
        bit         commit;
        int         r0, c0;
        for (int i = 0; i < 32; i++) begin md[i] = '0; mm[i] = 1'b0; end
        for (int i = 0; i < n; i++) begin
            int o;
            o = (int'(addr[4:0]) + i) % 32;
            md[o] = 8'((seed + i * 37) & 255);
            mm[o] = 1'b1;
        end
        commit = !partial && n > 0;
        if (commit) begin
            for (int o = 0; o < 32; o++) begin
                if (mm[o]) begin
                    q_addr.push_back({addr[15:5], 5'(o)});
                    q_data.push_back(md[o]);
                end
            end
        end
        r0 = rises; c0 = clrs;
        @(negedge clk); wr_start = 1'b1; start_addr = addr;
        @(negedge clk); wr_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            byte_vld = 1'b1; byte_data = 8'((seed + i * 37) & 255);
            @(negedge clk); byte_vld = 1'b0;
            if (i % 3 == 1) @(negedge clk);
        end
        cs_rise = 1'b1; bit_partial = partial;
        @(negedge clk); cs_rise = 1'b0; bit_partial = 1'b0;
        check(busy == commit, "R4", {req, " busy after rise"}, busy, commit);
        if (noise) begin
            repeat (5) @(negedge clk);
            wr_start = 1'b1; start_addr = 16'h0000; byte_vld = 1'b1; byte_data = 8'hEE;
            @(negedge clk); wr_start = 1'b0;
            @(negedge clk); cs_rise = 1'b1;
            @(negedge clk); cs_rise = 1'b0; byte_vld = 1'b0;
        end
        repeat (P + 6) @(negedge clk);
        check(q_addr.size() == 0, "R3", {req, " pending writes"}, q_addr.size(), 0);
        check(rises - r0 == int'(commit), "R5", {req, " busy windows"}, rises - r0, commit);
        check(clrs - c0 == int'(commit), "R8", {req, " clear pulses"}, clrs - c0, commit);
        if (commit) check(last_len == P, "R7", {req, " busy length"}, last_len, P);
        q_addr.delete(); q_data.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && wel_clr == 1'b0 && arr_we == 1'b0, "R10", "reset outputs",
              {busy, wel_clr, arr_we}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R11: strobes in idle have no effect
        byte_vld = 1'b1; byte_data = 8'h5A; @(negedge clk); byte_vld = 1'b0;
        cs_rise = 1'b1; @(negedge clk); cs_rise = 1'b0;
        repeat (4) @(negedge clk);
        check(rises == 0 && clrs == 0, "R11", "idle strobes", rises + clrs, 0);
        // R11: the idle byte must not appear in the next transfer
        do_write(16'h1A45, 1, 8'h3C, 1'b0, 1'b0, "R11");
        // R1: wrap inside the page from offset 30
        do_write(16'h0F3E, 5, 8'h11, 1'b0, 1'b0, "R1");
        // R2: 40 bytes overwrite earlier offsets
        do_write(16'hC7E3, 40, 8'h80, 1'b0, 1'b0, "R2");
        // R6: no data bytes
        do_write(16'h2200, 0, 0, 1'b0, 1'b0, "R6");
        // R5: rise in the middle of a byte
        do_write(16'h3308, 3, 8'h42, 1'b1, 1'b0, "R5");
        // R9 and R3: sparse bytes, strobes while busy
        do_write(16'hABCA, 3, 8'h07, 1'b0, 1'b1, "R9");
        // R1: full page starting at offset 0
        do_write(16'hFFE0, 32, 8'hF0, 1'b0, 1'b0, "R1");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule